// File: doc/BRIEF.md
# Paired-Page Translation Lookup Unit

This block is a fully associative translation lookaside buffer that turns a virtual address into a physical address. Each slot covers a pair of adjacent virtual pages: one descriptor gives the shared upper address bits, an address-space tag and a global flag, and two page descriptors hold the frame number, valid flag and dirty flag for the even and odd halves. Each slot also has its own page size, decoded from a size mask, so small and large pages can sit side by side.

A request carries a virtual address, the current address-space tag and a read/write flag. One cycle later the unit returns a registered response. It is either a physical address with a permission level, or a classified fault: a refill when no slot matches, an invalid fault when the matching half is not valid, or a modified fault when a write hits a clean half. Every response also carries the faulting address, its pair number and the tag, ready to load into the fault context registers. Slots are loaded one at a time through an indexed write port.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset `rsp_valid` is low and every slot is cleared: pair number 0, tag 0, not global, both halves invalid. A read of an address below 0x2000 with tag 0 then returns the invalid fault (code 2, refill 0).
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and the response reflects that request.
- R3: A slot matches when the address bits above the pair boundary equal the slot's pair number and either the tags are equal or the slot's global flag is set. The pair number field holds address bits 31..13.
- R4: The address bit at the page shift picks the odd half (1) or the even half (0). That half supplies the valid flag, dirty flag and frame number.
- R5: The size field `wr_mask` holds address bits 24..13. Its values 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF give page shifts 12, 14, 16, 18, 20, 22 and 24. Address bits below shift+1 are left out of the match.
- R6: On success `rsp_pa` = (frame << 12) | (address & (2^shift − 1)).
- R7: On success `rsp_ok`=1 and `rsp_code`=0. `rsp_level` is 2 when the selected half is dirty and 1 when it is clean.
- R8: When no slot matches, `rsp_refill`=1 and `rsp_code` is 2 for a read or 3 for a write.
- R9: When a slot matches but the selected half is not valid, `rsp_refill`=0 and `rsp_code` is 2 for a read or 3 for a write.
- R10: A write that hits a valid but clean half gives `rsp_code`=1 with `rsp_refill`=0. A read of the same half succeeds at level 1.
- R11: When several slots match, the lowest index decides the result.
- R12: Every response reports the request's address on `rsp_badva`, its bits 31..13 on `rsp_vpn2` and its tag on `rsp_asid`.
- R13: A write on the load port replaces the whole slot at `wr_idx`. From the next cycle on, lookups see only the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Load one slot |
| wr_idx | input | 6 | Slot index to load |
| wr_mask | input | 12 | Page size field (address bits 24..13) |
| wr_vpn2 | input | 19 | Pair number (address bits 31..13) |
| wr_asid | input | 8 | Address-space tag |
| wr_global | input | 1 | Match any tag |
| wr_pfn0 | input | 24 | Even half frame number |
| wr_v0 | input | 1 | Even half valid |
| wr_d0 | input | 1 | Even half dirty (writable) |
| wr_pfn1 | input | 24 | Odd half frame number |
| wr_v1 | input | 1 | Odd half valid |
| wr_d1 | input | 1 | Odd half dirty (writable) |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | 36 | Physical address |
| rsp_level | output | 2 | 2 writable, 1 read only, 0 on a fault |
| rsp_code | output | 2 | 0 none, 1 modified, 2 load fault, 3 store fault |
| rsp_refill | output | 1 | Fault came from a miss |
| rsp_badva | output | 32 | Address of the request |
| rsp_vpn2 | output | 19 | Pair number of the request |
| rsp_asid | output | 8 | Tag of the request |

## Verification
The bench aims at the half-select bit, which moves with the page size. A unit that always picked the odd half from bit 12 would return the wrong frame for 64 KB and 16 MB pages, and a unit that compared too many bits would turn those large-page hits into refills. It separates the three fault kinds for both reads and writes. Mixing up the refill flag would send a missing mapping to the invalid handler, and losing the dirty check would let a write reach a clean page. It loads two matching slots to test that the lower index wins, then reloads one of them to show that a write replaces the slot and the lookup moves to the other.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
   localparam int MASK_W   = 12;
   localparam int BASE_SH  = 12;

   localparam logic [1:0] CODE_NONE = 2'd0;
   localparam logic [1:0] CODE_MOD  = 2'd1;
   localparam logic [1:0] CODE_LOAD = 2'd2;
   localparam logic [1:0] CODE_STOR = 2'd3;

   function automatic logic [4:0] size_shift(input logic [MASK_W-1:0] m);
      case (m)
         12'h003: size_shift = 5'd14;
         12'h00F: size_shift = 5'd16;
         12'h03F: size_shift = 5'd18;
         12'h0FF: size_shift = 5'd20;
         12'h3FF: size_shift = 5'd22;
         12'hFFF: size_shift = 5'd24;
         default: size_shift = 5'd12;
      endcase
   endfunction
endpackage

// File: rtl/tlb_pair_slot.sv
module tlb_pair_slot
   import tlb_pair_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int ASID_W = 8,
   parameter int PFN_W  = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic [MASK_W-1:0] ld_mask,
   input  logic [VA_W-14:0]  ld_vpn2,
   input  logic [ASID_W-1:0] ld_asid,
   input  logic              ld_glb,
   input  logic [PFN_W-1:0]  ld_pfn0,
   input  logic              ld_v0,
   input  logic              ld_d0,
   input  logic [PFN_W-1:0]  ld_pfn1,
   input  logic              ld_v1,
   input  logic              ld_d1,
   input  logic [VA_W-1:0]   va,
   input  logic [ASID_W-1:0] asid,
   output logic              hit,
   output logic              sel_v,
   output logic              sel_d,
   output logic [PFN_W-1:0]  sel_pfn,
   output logic [4:0]        shift
);
   localparam int VPN_W = VA_W - 13;

   logic [MASK_W-1:0] mask_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [ASID_W-1:0] asid_q;
   logic              glb_q, v0_q, d0_q, v1_q, d1_q;
   logic [PFN_W-1:0]  pfn0_q, pfn1_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= '0; vpn_q <= '0; asid_q <= '0; glb_q <= 1'b0;
         pfn0_q <= '0; v0_q <= 1'b0; d0_q <= 1'b0;
         pfn1_q <= '0; v1_q <= 1'b0; d1_q <= 1'b0;
      end else if (ld) begin
         mask_q <= ld_mask; vpn_q <= ld_vpn2; asid_q <= ld_asid; glb_q <= ld_glb;
         pfn0_q <= ld_pfn0; v0_q <= ld_v0; d0_q <= ld_d0;
         pfn1_q <= ld_pfn1; v1_q <= ld_v1; d1_q <= ld_d1;
      end
   end

   logic [VPN_W-1:0] ign;
   logic             odd;

   always_comb begin
      shift = size_shift(mask_q);
      for (int j = 0; j < VPN_W; j++)
         ign[j] = (j < (int'(shift) - BASE_SH));
      odd     = va[shift];
      hit     = (((va[VA_W-1:13] ^ vpn_q) & ~ign) == '0) &&
                (glb_q || (asid_q == asid));
      sel_v   = odd ? v1_q   : v0_q;
      sel_d   = odd ? d1_q   : d0_q;
      sel_pfn = odd ? pfn1_q : pfn0_q;
   end
endmodule

// File: rtl/tlb_pair_pick.sv
module tlb_pair_pick #(
   parameter int N     = 48,
   parameter int PFN_W = 24
) (
   input  logic [N-1:0]            hit_vec,
   input  logic [N-1:0]            v_vec,
   input  logic [N-1:0]            d_vec,
   input  logic [N-1:0][PFN_W-1:0] pfn_vec,
   input  logic [N-1:0][4:0]       sh_vec,
   output logic                    any,
   output logic                    v,
   output logic                    d,
   output logic [PFN_W-1:0]        pfn,
   output logic [4:0]              sh
);
   always_comb begin
      any = 1'b0; v = 1'b0; d = 1'b0; pfn = '0; sh = 5'd12;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any = 1'b1;
            v   = v_vec[i];
            d   = d_vec[i];
            pfn = pfn_vec[i];
            sh  = sh_vec[i];
         end
      end
   end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
   import tlb_pair_pkg::*;
#(
   parameter int N_SLOTS = 48,
   parameter int VA_W    = 32,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 24,
   localparam int IDX_W  = $clog2(N_SLOTS),
   localparam int VPN_W  = VA_W - 13,
   localparam int PA_W   = PFN_W + 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [11:0]       wr_mask,
   input  logic [VPN_W-1:0]  wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PFN_W-1:0]  wr_pfn0,
   input  logic              wr_v0,
   input  logic              wr_d0,
   input  logic [PFN_W-1:0]  wr_pfn1,
   input  logic              wr_v1,
   input  logic              wr_d1,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [1:0]        rsp_level,
   output logic [1:0]        rsp_code,
   output logic              rsp_refill,
   output logic [VA_W-1:0]   rsp_badva,
   output logic [VPN_W-1:0]  rsp_vpn2,
   output logic [ASID_W-1:0] rsp_asid
);
   if (VA_W < 26 || VA_W > 64) begin : g_bad_va
      $error("VA_W must lie in 26..64");
   end
   if (N_SLOTS < 2) begin : g_bad_n
      $error("N_SLOTS must be at least 2");
   end
   if (PFN_W < 1) begin : g_bad_pfn
      $error("PFN_W must be positive");
   end

   logic [N_SLOTS-1:0]            hit_vec, v_vec, d_vec;
   logic [N_SLOTS-1:0][PFN_W-1:0] pfn_vec;
   logic [N_SLOTS-1:0][4:0]       sh_vec;

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      tlb_pair_slot #(.VA_W(VA_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_slot (
         .clk(clk), .rst(rst),
         .ld(wr_en && (wr_idx == IDX_W'(g))),
         .ld_mask(wr_mask), .ld_vpn2(wr_vpn2), .ld_asid(wr_asid),
         .ld_glb(wr_global),
         .ld_pfn0(wr_pfn0), .ld_v0(wr_v0), .ld_d0(wr_d0),
         .ld_pfn1(wr_pfn1), .ld_v1(wr_v1), .ld_d1(wr_d1),
         .va(lk_va), .asid(lk_asid),
         .hit(hit_vec[g]), .sel_v(v_vec[g]), .sel_d(d_vec[g]),
         .sel_pfn(pfn_vec[g]), .shift(sh_vec[g])
      );
   end

   logic             any_hit, w_v, w_d;
   logic [PFN_W-1:0] w_pfn;
   logic [4:0]       w_sh;

   tlb_pair_pick #(.N(N_SLOTS), .PFN_W(PFN_W)) u_pick (
      .hit_vec(hit_vec), .v_vec(v_vec), .d_vec(d_vec),
      .pfn_vec(pfn_vec), .sh_vec(sh_vec),
      .any(any_hit), .v(w_v), .d(w_d), .pfn(w_pfn), .sh(w_sh)
   );

   logic [VA_W-1:0] offm;
   logic [PA_W-1:0] pa_c;
   logic            ok_c;
   logic [1:0]      code_c;
   logic [1:0]      fault_c;

   always_comb begin
      for (int k = 0; k < VA_W; k++)
         offm[k] = (k < int'(w_sh));
      pa_c    = {w_pfn, 12'h000} | PA_W'(lk_va & offm);
      fault_c = lk_write ? CODE_STOR : CODE_LOAD;
      ok_c    = any_hit && w_v && (w_d || !lk_write);
      if (ok_c)                code_c = CODE_NONE;
      else if (any_hit && w_v) code_c = CODE_MOD;
      else                     code_c = fault_c;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0; rsp_ok <= 1'b0; rsp_pa <= '0; rsp_level <= 2'd0;
         rsp_code <= CODE_NONE; rsp_refill <= 1'b0;
         rsp_badva <= '0; rsp_vpn2 <= '0; rsp_asid <= '0;
      end else begin
         rsp_valid <= lk_valid;
         if (lk_valid) begin
            rsp_ok     <= ok_c;
            rsp_pa     <= ok_c ? pa_c : '0;
            rsp_level  <= ok_c ? (w_d ? 2'd2 : 2'd1) : 2'd0;
            rsp_code   <= code_c;
            rsp_refill <= !any_hit;
            rsp_badva  <= lk_va;
            rsp_vpn2   <= lk_va[VA_W-1:13];
            rsp_asid   <= lk_asid;
         end
      end
   end

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> $past(lk_valid));
   // R7
   ok_level_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_ok) |-> (rsp_level != 2'd0 && rsp_code == CODE_NONE && !rsp_refill));
   // R8
   refill_code_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_refill) |-> (rsp_code == CODE_LOAD || rsp_code == CODE_STOR));
   // R10
   mod_write_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_code == CODE_MOD) |-> (!rsp_refill && $past(lk_write)));
   // R12
   badva_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && lk_valid && $stable(lk_va)) |=> (rsp_badva == $past(lk_va)));
endmodule

// File: tb/tlb_pair_lookup_tb.sv
module tlb_pair_lookup_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [11:0] wr_mask = '0;
   logic [18:0] wr_vpn2 = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [23:0] wr_pfn0 = '0, wr_pfn1 = '0;
   logic        wr_v0 = 1'b0, wr_d0 = 1'b0, wr_v1 = 1'b0, wr_d1 = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_write = 1'b0;
   logic        rsp_valid, rsp_ok, rsp_refill;
   logic [35:0] rsp_pa;
   logic [1:0]  rsp_level, rsp_code;
   logic [31:0] rsp_badva;
   logic [18:0] rsp_vpn2;
   logic [7:0]  rsp_asid;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_pair_lookup u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
      .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_pfn0(wr_pfn0), .wr_v0(wr_v0), .wr_d0(wr_d0),
      .wr_pfn1(wr_pfn1), .wr_v1(wr_v1), .wr_d1(wr_d1),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_level(rsp_level),
      .rsp_code(rsp_code), .rsp_refill(rsp_refill), .rsp_badva(rsp_badva),
      .rsp_vpn2(rsp_vpn2), .rsp_asid(rsp_asid)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load(input int idx, input logic [11:0] m, input logic [18:0] vpn,
                       input logic [7:0] a, input logic g,
                       input logic [23:0] p0, input logic v0, input logic d0,
                       input logic [23:0] p1, input logic v1, input logic d1);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 6'(idx); wr_mask = m; wr_vpn2 = vpn; wr_asid = a;
      wr_global = g; wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0;
      wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // one request; the response is registered and read at the following negedge
   task automatic look(input logic [31:0] va, input logic [7:0] a, input logic w);
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_asid = a; lk_write = w;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic expect_ok(input string req, input logic [35:0] pa, input logic [1:0] lvl);
      chk(req, {63'd0, rsp_ok}, 64'd1);
      chk(req, {28'd0, rsp_pa}, {28'd0, pa});
      chk(req, {62'd0, rsp_level}, {62'd0, lvl});
   endtask

   task automatic expect_fault(input string req, input logic [1:0] code, input logic refill);
      chk(req, {63'd0, rsp_ok}, 64'd0);
      chk(req, {62'd0, rsp_code}, {62'd0, code});
      chk(req, {63'd0, rsp_refill}, {63'd0, refill});
   endtask

   task automatic t_reset;
      // R1 reset state and cleared slots
      chk("R1 valid after reset", {63'd0, rsp_valid}, 64'd0);
      look(32'h0000_0100, 8'h00, 1'b0);
      chk("R2 valid follows req", {63'd0, rsp_valid}, 64'd1);
      expect_fault("R1 cleared slot invalid", 2'd2, 1'b0);
      @(negedge clk);
      chk("R2 valid drops", {63'd0, rsp_valid}, 64'd0);
   endtask

   task automatic t_fill;
      for (int i = 0; i < 48; i++)
         load(i, 12'h000, 19'h40000 + 19'(i), 8'hEE, 1'b0, 24'h0, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0);
   endtask

   task automatic t_small;
      load(5, 12'h000, 19'h00012, 8'h11, 1'b0, 24'h000ABC, 1'b1, 1'b1, 24'h000DEF, 1'b1, 1'b0);
      look(32'h0002_4123, 8'h11, 1'b0);
      expect_ok("R3 R6 R7 even 4K", 36'h0_00AB_C123, 2'd2);
      look(32'h0002_5456, 8'h11, 1'b0);
      expect_ok("R4 R10 odd 4K read", 36'h0_00DE_F456, 2'd1);
      look(32'h0002_5456, 8'h11, 1'b1);
      expect_fault("R10 write clean", 2'd1, 1'b0);
      look(32'h0002_4010, 8'h12, 1'b0);
      expect_fault("R8 tag miss read", 2'd2, 1'b1);
      chk("R12 badva", {32'd0, rsp_badva}, 64'h0002_4010);
      chk("R12 vpn2", {45'd0, rsp_vpn2}, 64'h12);
      chk("R12 asid", {56'd0, rsp_asid}, 64'h12);
      look(32'h0002_4010, 8'h12, 1'b1);
      expect_fault("R8 tag miss write", 2'd3, 1'b1);
   endtask

   task automatic t_global;
      load(7, 12'h000, 19'h00030, 8'h22, 1'b1, 24'h000111, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
      look(32'h0006_0010, 8'h99, 1'b0);
      expect_ok("R3 global", 36'h0_0011_1010, 2'd2);
   endtask

   task automatic t_invalid;
      load(9, 12'h000, 19'h00040, 8'h11, 1'b0, 24'h000222, 1'b0, 1'b1, 24'h0, 1'b0, 1'b0);
      look(32'h0008_0000, 8'h11, 1'b0);
      expect_fault("R9 invalid read", 2'd2, 1'b0);
      look(32'h0008_0004, 8'h11, 1'b1);
      expect_fault("R9 invalid write", 2'd3, 1'b0);
   endtask

   task automatic t_large;
      load(11, 12'h00F, 19'h00100, 8'h33, 1'b0, 24'h002000, 1'b1, 1'b1, 24'h003000, 1'b1, 1'b1);
      look(32'h0020_ABCD, 8'h33, 1'b0);
      expect_ok("R5 R6 64K even", 36'h0_0200_ABCD, 2'd2);
      look(32'h0021_1234, 8'h33, 1'b1);
      expect_ok("R4 R5 64K odd", 36'h0_0300_1234, 2'd2);
      look(32'h0022_0000, 8'h33, 1'b0);
      expect_fault("R5 outside pair", 2'd2, 1'b1);
      load(13, 12'hFFF, 19'h20000, 8'h44, 1'b0, 24'h005000, 1'b1, 1'b1, 24'h006000, 1'b1, 1'b0);
      look(32'h40FF_FFFF, 8'h44, 1'b0);
      expect_ok("R5 R6 16M even", 36'h0_05FF_FFFF, 2'd2);
      look(32'h4100_0010, 8'h44, 1'b0);
      expect_ok("R4 R7 16M odd", 36'h0_0600_0010, 2'd1);
   endtask

   task automatic t_prio;
      load(30, 12'h000, 19'h00050, 8'h55, 1'b0, 24'h000300, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
      load(20, 12'h000, 19'h00050, 8'h55, 1'b0, 24'h000200, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
      look(32'h000A_0000, 8'h55, 1'b0);
      expect_ok("R11 lowest index", 36'h0_0020_0000, 2'd2);
      load(20, 12'h000, 19'h00077, 8'h55, 1'b0, 24'h000200, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
      look(32'h000A_0000, 8'h55, 1'b0);
      expect_ok("R13 slot replaced", 36'h0_0030_0000, 2'd2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_fill();
      t_small();
      t_global();
      t_invalid();
      t_large();
      t_prio();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule